// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Unit

The block holds three identical 32-bit down counters behind a small register port. Each channel has a counter, a reload constant and a control register. One shared run register starts or freezes each channel on its own. A channel decrements once per tick of its selected count clock. The clock can be one of six prescaled taps of a peripheral clock enable, a slow tick at real-time-clock rate, or an external tick.

When a counter at zero takes another tick, it loads its reload constant and sets a sticky underflow flag. The channel's interrupt line is high while both that flag and its enable bit are set. Software can clear the flag but can never set it. Any write to a channel's count register loads the new value and resets that channel's prescaler phase.

Reads are combinational from `reg_addr`. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `tmr_unit`

## Requirements
- R1: After reset every count and reload register reads 0xFFFFFFFF, every control register reads 0, the run register reads 0 and all three interrupt lines are low.
- R2: Bit n of the run register (offset 0x04, bits 2:0) runs channel n. While the bit is 0 the count holds its value. Setting the bit again resumes counting from that value, in the prescaler phase it had when stopped.
- R3: Control bits 2:0 with codes 0, 1, 2, 3 and 4 make the channel decrement once every 4, 16, 64, 256 and 1024 cycles with `pclk_en` high while it runs. The first decrement comes on the last of those enables after a count write.
- R4: Control code 5 decrements once every 4096 enabled cycles.
- R5: Control code 6 decrements once per cycle with `rtc_tick` high, and code 7 once per cycle with `ext_tick` high. The other tick input has no effect.
- R6: A tick taken while the count is 0 loads the reload register into the count and sets control bit 8, the underflow flag.
- R7: A control write stores bit 8 as the old flag ANDed with the written bit. Writing 0 clears the flag; writing 1 never sets a clear flag.
- R8: `irq[n]` is high exactly when control bits 8 and 5 of channel n are both 1. It follows a control write from the next cycle.
- R9: Control bit 9 is stored and read back with no other effect. Control bits other than 9, 8, 5 and 2:0 read as 0.
- R10: A write to a channel's count register loads the value and clears that channel's prescaler phase, including while the channel runs. The write wins over a tick in the same cycle.
- R11: Channel n's reload register sits at 0x08+12n, its count register at 0x0C+12n and its control register at 0x10+12n. Reads of any other offset return 0, and writes to them change nothing.
- R12: A channel's registers and ticks affect no other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pclk_en | input | 1 | Peripheral clock enable feeding the prescalers |
| rtc_tick | input | 1 | Slow tick, counted under code 6 |
| ext_tick | input | 1 | External tick, counted under code 7 |
| irq | output | 3 | Per-channel underflow interrupt |

## Verification
Every prescaler code is run for one enable short of its divide ratio, exactly the ratio, and two and a half ratios. This separates an off-by-one in the tap from a wrong tap. The same run is repeated with `pclk_en` at half rate to show that only enabled cycles count. RTC and external pulses are sent together under each of codes 6 and 7, so a swapped or merged source shows up as a wrong count. Underflow is driven through the flag set, both write values of the flag and every enable combination. A count write in the middle of a prescaler period shows whether the phase really restarts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // control register field positions
    localparam int CTL_SEL_LSB = 0;
    localparam int CTL_IE_BIT  = 5;
    localparam int CTL_UNF_BIT = 8;
    localparam int CTL_CAP_BIT = 9;

    typedef enum logic [2:0] {
        SRC_DIV4    = 3'd0,
        SRC_DIV16   = 3'd1,
        SRC_DIV64   = 3'd2,
        SRC_DIV256  = 3'd3,
        SRC_DIV1024 = 3'd4,
        SRC_DIV4096 = 3'd5,
        SRC_RTC     = 3'd6,
        SRC_EXT     = 3'd7
    } clk_src_e;

    typedef struct packed {
        logic     cap;
        logic     unf;
        logic     ie;
        clk_src_e src;
    } ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PW = 12
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv_i,
    input  logic     clr_i,
    input  clk_src_e src_i,
    output logic     tick_o
);
    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] mask;

    always_comb begin
        // divide ratio is 4^(code+1); codes 6/7 bypass the prescaler
        mask   = PW'((32'd1 << (2 * 32'(src_i) + 2)) - 32'd1);
        tick_o = adv_i && ((pre_q & mask) == mask);
        pre_d  = pre_q;
        if (clr_i)
            pre_d = '0;
        else if (adv_i)
            pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R10
    clr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pre_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          pclk_en_i,
    input  logic          rtc_tick_i,
    input  logic          ext_tick_i,
    input  logic          rld_wr_i,
    input  logic          cnt_wr_i,
    input  logic          ctl_wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rld_o,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] ctl_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [DW-1:0] rld;
        logic [DW-1:0] cnt;
        ctl_t          ctl;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      pre_tick;
    logic      tick;
    logic      uf;

    tmr_prescaler #(.PW(PW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (run_i && pclk_en_i),
        .clr_i  (cnt_wr_i),
        .src_i  (st_q.ctl.src),
        .tick_o (pre_tick)
    );

    always_comb begin
        unique case (st_q.ctl.src)
            SRC_RTC: tick = run_i && rtc_tick_i;
            SRC_EXT: tick = run_i && ext_tick_i;
            default: tick = pre_tick;
        endcase
        uf   = tick && !cnt_wr_i && (st_q.cnt == '0);
        st_d = st_q;
        if (rld_wr_i)
            st_d.rld = wdata_i;
        if (cnt_wr_i)
            st_d.cnt = wdata_i;
        else if (tick)
            st_d.cnt = uf ? st_q.rld : st_q.cnt - 1'b1;
        if (ctl_wr_i) begin
            st_d.ctl.src = clk_src_e'(wdata_i[CTL_SEL_LSB +: 3]);
            st_d.ctl.ie  = wdata_i[CTL_IE_BIT];
            st_d.ctl.cap = wdata_i[CTL_CAP_BIT];
            st_d.ctl.unf = st_q.ctl.unf & wdata_i[CTL_UNF_BIT];
        end
        if (uf)
            st_d.ctl.unf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rld <= '1;
            st_q.cnt <= '1;
            st_q.ctl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctl_o = '0;
        ctl_o[CTL_SEL_LSB +: 3] = st_q.ctl.src;
        ctl_o[CTL_IE_BIT]       = st_q.ctl.ie;
        ctl_o[CTL_UNF_BIT]      = st_q.ctl.unf;
        ctl_o[CTL_CAP_BIT]      = st_q.ctl.cap;
        rld_o = st_q.rld;
        cnt_o = st_q.cnt;
        irq_o = st_q.ctl.unf && st_q.ctl.ie;
    end

    // R6
    unf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ctl.unf) |-> ($past(st_q.cnt) == '0 && $past(tick)));
    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr_i && !rld_wr_i && st_q.cnt == '0) |=> (st_q.cnt == $past(st_q.rld)));
    // R7
    unf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && !wdata_i[CTL_UNF_BIT] && !uf) |=> !st_q.ctl.unf);
    // R2
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_wr_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
    parameter int NCH = 3,
    parameter int DW  = 32,
    parameter int AW  = 8,
    parameter int PW  = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  reg_addr,
    input  logic           reg_wr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           pclk_en,
    input  logic           rtc_tick,
    input  logic           ext_tick,
    output logic [NCH-1:0] irq
);
    localparam logic [AW-1:0] A_RUN   = AW'(8'h04);
    localparam int            CH_BASE = 8;
    localparam int            STRIDE  = 12;

    typedef struct packed {
        logic [NCH-1:0] run;
    } top_state_t;

    top_state_t top_d, top_q;
    logic [DW-1:0] rld_rd [NCH];
    logic [DW-1:0] cnt_rd [NCH];
    logic [DW-1:0] ctl_rd [NCH];

    always_comb begin
        top_d = top_q;
        if (reg_wr && reg_addr == A_RUN)
            top_d.run = reg_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [AW-1:0] A_RLD = AW'(CH_BASE + STRIDE * i);
        localparam logic [AW-1:0] A_CNT = AW'(CH_BASE + STRIDE * i + 4);
        localparam logic [AW-1:0] A_CTL = AW'(CH_BASE + STRIDE * i + 8);

        tmr_channel #(.DW(DW), .PW(PW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (top_q.run[i]),
            .pclk_en_i  (pclk_en),
            .rtc_tick_i (rtc_tick),
            .ext_tick_i (ext_tick),
            .rld_wr_i   (reg_wr && reg_addr == A_RLD),
            .cnt_wr_i   (reg_wr && reg_addr == A_CNT),
            .ctl_wr_i   (reg_wr && reg_addr == A_CTL),
            .wdata_i    (reg_wdata),
            .rld_o      (rld_rd[i]),
            .cnt_o      (cnt_rd[i]),
            .ctl_o      (ctl_rd[i]),
            .irq_o      (irq[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_RUN)
            reg_rdata[NCH-1:0] = top_q.run;
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == AW'(CH_BASE + STRIDE * i))     reg_rdata = rld_rd[i];
            if (reg_addr == AW'(CH_BASE + STRIDE * i + 4)) reg_rdata = cnt_rd[i];
            if (reg_addr == AW'(CH_BASE + STRIDE * i + 8)) reg_rdata = ctl_rd[i];
        end
    end

    // R2
    run_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_RUN) |=> (top_q.run == $past(reg_wdata[NCH-1:0])));
endmodule

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pclk_en = 1'b1;
    logic        pclk_half = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;

    tmr_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pclk_en(pclk_en),
        .rtc_tick(rtc_tick), .ext_tick(ext_tick), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(negedge clk) pclk_en <= pclk_half ? ~pclk_en : 1'b1;

    function automatic logic [7:0] a_rld(int ch); return 8'(8 + 12*ch);  endfunction
    function automatic logic [7:0] a_cnt(int ch); return 8'(12 + 12*ch); endfunction
    function automatic logic [7:0] a_ctl(int ch); return 8'(16 + 12*ch); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a negedge; the write lands on the next posedge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(logic r, logic e);
        rtc_tick = r; ext_tick = e;
        @(negedge clk);
        rtc_tick = 1'b0; ext_tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int ch = 0; ch < 3; ch++) begin
            rd(a_rld(ch), v); chk("R1 reload", v, 32'hFFFFFFFF);
            rd(a_cnt(ch), v); chk("R1 count", v, 32'hFFFFFFFF);
            rd(a_ctl(ch), v); chk("R1 control", v, 32'h0);
        end
        rd(8'h04, v); chk("R1 run", v, 32'h0);
        chk("R1 irq", {29'b0, irq}, 32'h0);

        // R3 R4 prescaler sweep; k enabled run edges give k/div decrements
        for (int ch = 0; ch < 3; ch++) begin
            for (int code = 0; code < 6; code++) begin
                int div;
                if (ch > 0 && code > 1) continue;
                div = (code == 5) ? 4096 : (4 << (2*code));
                for (int j = 0; j < 3; j++) begin
                    int k;
                    k = (j == 0) ? div - 1 : (j == 1) ? div : 2*div + div/2;
                    wr(a_ctl(ch), 32'(code));
                    wr(a_cnt(ch), 32'd1000);
                    wr(8'h04, 32'(1 << ch));
                    repeat (k-1) @(negedge clk);
                    wr(8'h04, 32'h0);
                    rd(a_cnt(ch), v);
                    chk(code == 5 ? "R4 div4096" : "R3 prescale", v, 32'(1000 - k/div));
                end
            end
        end

        // R3 half-rate enable: 16 run edges carry 8 enables -> 2 decrements at /4
        wr(a_ctl(0), 32'h0);
        wr(a_cnt(0), 32'd500);
        pclk_half = 1'b1;
        wr(8'h04, 32'h1);
        repeat (15) @(negedge clk);
        wr(8'h04, 32'h0);
        pclk_half = 1'b0;
        rd(a_cnt(0), v); chk("R3 gated enable", v, 32'd498);

        // R2 freeze and resume
        wr(a_cnt(0), 32'd200);
        wr(8'h04, 32'h1);
        repeat (5) @(negedge clk);      // 6 run edges -> 1 decrement, phase 2
        wr(8'h04, 32'h0);
        rd(a_cnt(0), v); chk("R2 stopped value", v, 32'd199);
        repeat (40) @(negedge clk);
        rd(a_cnt(0), v); chk("R2 frozen", v, 32'd199);
        wr(8'h04, 32'h1);               // phase 2 kept: 2 more edges give a tick
        @(negedge clk);
        wr(8'h04, 32'h0);
        rd(a_cnt(0), v); chk("R2 resume phase", v, 32'd198);

        // R10 count write while running restarts prescaler
        wr(a_cnt(0), 32'd100);
        wr(8'h04, 32'h1);
        repeat (5) @(negedge clk);      // edges 1..5: decrement at 4, phase 1
        wr(a_cnt(0), 32'd50);           // edge 6: write wins, phase cleared
        repeat (3) @(negedge clk);
        rd(a_cnt(0), v); chk("R10 phase restart", v, 32'd50);
        @(negedge clk);
        rd(a_cnt(0), v); chk("R10 first tick", v, 32'd49);
        wr(8'h04, 32'h0);

        // R5 code 6 counts rtc only; R12 channel 1 on code 7 counts ext only
        wr(a_ctl(0), 32'h6);
        wr(a_cnt(0), 32'd5);
        wr(a_ctl(1), 32'h7);
        wr(a_cnt(1), 32'd9);
        wr(a_cnt(2), 32'd77);
        wr(a_ctl(2), 32'h0);
        wr(8'h04, 32'h3);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        wr(8'h04, 32'h0);
        rd(a_cnt(0), v); chk("R5 rtc source", v, 32'd2);
        rd(a_cnt(1), v); chk("R5 ext source", v, 32'd7);
        rd(a_cnt(2), v); chk("R12 idle channel", v, 32'd77);

        // R6 underflow on channel 0 (code 6)
        wr(a_rld(0), 32'd7);
        wr(a_cnt(0), 32'd1);
        wr(8'h04, 32'h1);
        pulse(1'b1, 1'b0);
        rd(a_cnt(0), v); chk("R6 reach zero", v, 32'd0);
        rd(a_ctl(0), v); chk("R6 no flag yet", v, 32'h006);
        pulse(1'b1, 1'b0);
        rd(a_cnt(0), v); chk("R6 reload", v, 32'd7);
        rd(a_ctl(0), v); chk("R6 flag set", v, 32'h106);
        chk("R8 irq masked", {29'b0, irq}, 32'h0);
        rd(a_ctl(1), v); chk("R12 other flag", v, 32'h007);
        pulse(1'b1, 1'b0);
        rd(a_cnt(0), v); chk("R6 after reload", v, 32'd6);
        wr(8'h04, 32'h0);

        // R8 R7 flag and enable
        wr(a_ctl(0), 32'h126);
        chk("R8 irq on", {29'b0, irq}, 32'h1);
        wr(a_ctl(0), 32'h026);
        rd(a_ctl(0), v); chk("R7 flag cleared", v, 32'h026);
        chk("R8 irq off", {29'b0, irq}, 32'h0);
        wr(a_ctl(0), 32'h126);
        rd(a_ctl(0), v); chk("R7 write one no set", v, 32'h026);
        chk("R7 irq stays low", {29'b0, irq}, 32'h0);

        // R9 capture bit stored, unused bits read 0
        wr(a_ctl(0), 32'hFFFFFEFF);
        rd(a_ctl(0), v); chk("R9 stored bits", v, 32'h227);
        wr(a_ctl(0), 32'h0);
        rd(a_ctl(0), v); chk("R9 cleared", v, 32'h0);

        // R11 map, stride and unmapped offsets
        for (int ch = 0; ch < 3; ch++) wr(a_rld(ch), 32'hA000 + 32'(ch));
        for (int ch = 0; ch < 3; ch++) begin
            rd(a_rld(ch), v); chk("R11 stride", v, 32'hA000 + 32'(ch));
        end
        wr(8'h00, 32'h7);
        wr(8'h2C, 32'h1234);
        wr(8'h40, 32'h1234);
        rd(8'h00, v); chk("R11 unmapped read", v, 32'h0);
        rd(8'h2C, v); chk("R11 unmapped gap", v, 32'h0);
        rd(8'h04, v); chk("R11 run untouched", v, 32'h0);
        rd(a_ctl(2), v); chk("R11 ch2 ctl untouched", v, 32'h0);
        rd(a_rld(2), v); chk("R11 ch2 rld untouched", v, 32'hA002);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule